// File: doc/BRIEF.md
# Dual-Bank Byte-Lane Memory

This block is the memory behind a processor bus with 16 data bits and 20 address bits. Storage is byte-wide: each word location is held as an even byte in a bank wired to the low data half and an odd byte in a bank wired to the high data half. The lowest address bit and an active-low upper-byte enable decide which of the two banks take part in an access. A single bus cycle therefore carries one aligned 16-bit word, a single even byte, or a single odd byte.

The address space holds a 4 KB ROM at the bottom and, directly above it, 8 KB of RAM built as two even/odd pairs. The ROM is one even/odd pair whose bytes are produced by a fixed formula, so no file is needed. Every location outside these regions is unmapped. The host raises a strobe for one clock with the write flag, address, upper-byte enable and write data. A read result appears on the registered read bus at the next clock edge. An access to an unmapped address raises a one-cycle flag.

Top module: `dualbank_mem`

## Requirements
- R1: During and right after reset, `bus_rdata` is 0000h and `bus_unmapped` is 0.
- R2: The even bank is enabled when `bus_addr[0]` is 0, and its byte always travels on `bus_wdata[7:0]` / `bus_rdata[7:0]`.
- R3: The odd bank is enabled when `bus_bhe_n` is 0, and its byte always travels on `bus_wdata[15:8]` / `bus_rdata[15:8]`.
- R4: A read returns 00h on the half of a bank that is not enabled. With `bus_addr[0]`=1 and `bus_bhe_n`=1, no bank is enabled: a read returns 0000h and a write changes nothing.
- R5: A byte write updates only the enabled bank. The other byte of the same word location keeps its value.
- R6: With `bus_addr[0]`=0 and `bus_bhe_n`=0, a write stores both bytes and a read returns both bytes as one word.
- R7: Inside a bank the location is `bus_addr[11:1]`. ROM spans 00000h–00FFFh, RAM pair 0 spans 01000h–01FFFh and RAM pair 1 spans 02000h–02FFFh, each with storage of its own.
- R8: At ROM word location i (i = `bus_addr[11:1]`), the even byte is i[7:0] XOR 5Ah and the odd byte is i[10:3] XOR C3h.
- R9: A write anywhere in 00000h–00FFFh has no effect on later ROM reads and does not raise `bus_unmapped`.
- R10: A strobed access at 03000h or above sets `bus_unmapped` to 1 for exactly the next cycle. A read there returns 0000h, and a write there changes no RAM. In every other cycle `bus_unmapped` is 0.
- R11: Read data appears on `bus_rdata` at the clock edge that ends the strobed read cycle. It holds that value until the next strobed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_strobe | input | 1 | One-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 20 | Byte address |
| bus_bhe_n | input | 1 | Active-low upper-byte (odd bank) enable |
| bus_wdata | input | 16 | Write data, even byte low, odd byte high |
| bus_rdata | output | 16 | Registered read data |
| bus_unmapped | output | 1 | One-cycle flag after an access outside ROM and RAM |

## Verification
Two functions can land on one edge: byte lane masking and region decode. For example, a byte read that also crosses the ROM/RAM boundary, or a write that is at once a ROM write and a byte write. The bench drives back-to-back strobes at 00FFEh, 01000h, 02FFEh and 03000h in every enable combination, including writes with a lane disabled. A scoreboard holds the expected word, lane mask and flag for each access. It compares them one clock later, then reads back neighbouring bytes to show that the disabled lane and the protected ROM kept their contents.

// File: rtl/dualbank_pkg.sv
package dualbank_pkg;

    parameter int ADDR_W     = 20;
    parameter int LANE_W     = 8;
    parameter int LANES      = 2;
    parameter int DATA_W     = LANE_W * LANES;
    parameter int BANK_IDX_W = 11;
    parameter int RAM_PAIRS  = 2;

    localparam int PAIR_BYTES = 1 << (BANK_IDX_W + 1);
    localparam int PAIR_SEL_W = (RAM_PAIRS > 1) ? $clog2(RAM_PAIRS) : 1;

    localparam logic [ADDR_W-1:0] ROM_END  = ADDR_W'(PAIR_BYTES);
    localparam logic [ADDR_W-1:0] RAM_BASE = ADDR_W'(PAIR_BYTES);
    localparam logic [ADDR_W-1:0] RAM_END  = ADDR_W'(PAIR_BYTES * (RAM_PAIRS + 1));

    localparam logic [LANE_W-1:0] ROM_EVEN_KEY = 8'h5A;
    localparam logic [LANE_W-1:0] ROM_ODD_KEY  = 8'hC3;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_ROM  = 2'd1,
        RGN_RAM  = 2'd2
    } region_e;

    typedef struct packed {
        region_e                 region;
        logic [PAIR_SEL_W-1:0]   pair;
        logic [BANK_IDX_W-1:0]   idx;
        logic                    en_lo;
        logic                    en_hi;
    } access_t;

    typedef struct packed {
        logic [LANE_W-1:0] hi;
        logic [LANE_W-1:0] lo;
    } word_t;

    function automatic logic [LANE_W-1:0] rom_byte(input logic odd_lane,
                                                   input logic [BANK_IDX_W-1:0] idx);
        if (odd_lane)
            return idx[BANK_IDX_W-1 -: LANE_W] ^ ROM_ODD_KEY;
        else
            return idx[LANE_W-1:0] ^ ROM_EVEN_KEY;
    endfunction

endpackage

// File: rtl/dualbank_decode.sv
module dualbank_decode
    import dualbank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              bhe_n,
    output access_t           acc
);
    logic [RAM_PAIRS-1:0] pair_hit;

    for (genvar p = 0; p < RAM_PAIRS; p++) begin : g_pair_hit
        localparam logic [ADDR_W-1:0] LO = ADDR_W'(PAIR_BYTES * (p + 1));
        localparam logic [ADDR_W-1:0] HI = ADDR_W'(PAIR_BYTES * (p + 2));
        assign pair_hit[p] = (addr >= LO) && (addr < HI);
    end

    always_comb begin
        acc        = '0;
        acc.idx    = addr[BANK_IDX_W:1];
        acc.en_lo  = ~addr[0];
        acc.en_hi  = ~bhe_n;
        acc.region = RGN_NONE;
        if (addr < ROM_END)
            acc.region = RGN_ROM;
        else if (|pair_hit)
            acc.region = RGN_RAM;
        for (int p = 0; p < RAM_PAIRS; p++) begin
            if (pair_hit[p])
                acc.pair = PAIR_SEL_W'(p);
        end
    end
endmodule

// File: rtl/dualbank_ram_bank.sv
module dualbank_ram_bank
    import dualbank_pkg::*;
#(
    parameter int IDX_W = BANK_IDX_W,
    parameter int W     = LANE_W
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[idx] <= wdata;
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/dualbank_rom_bank.sv
module dualbank_rom_bank
    import dualbank_pkg::*;
#(
    parameter bit ODD = 1'b0
) (
    input  logic [BANK_IDX_W-1:0] idx,
    output logic [LANE_W-1:0]     rdata
);
    assign rdata = rom_byte(ODD, idx);
endmodule

// File: rtl/dualbank_mem.sv
module dualbank_mem
    import dualbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_strobe,
    input  logic              bus_we,
    input  logic [19:0]       bus_addr,
    input  logic              bus_bhe_n,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              bus_unmapped
);
    access_t acc;
    word_t   wr_word;
    word_t   rom_word;
    word_t   ram_word;
    word_t   next_word;
    word_t   rdata_q;
    logic    unmapped_q;
    logic    ram_wr;

    logic [LANE_W-1:0] ram_rd_lo [RAM_PAIRS];
    logic [LANE_W-1:0] ram_rd_hi [RAM_PAIRS];

    assign wr_word = word_t'(bus_wdata);

    dualbank_decode u_decode (
        .addr  (bus_addr),
        .bhe_n (bus_bhe_n),
        .acc   (acc)
    );

    assign ram_wr = bus_strobe && bus_we && (acc.region == RGN_RAM);

    for (genvar p = 0; p < RAM_PAIRS; p++) begin : g_ram_pair
        logic pair_sel;
        assign pair_sel = (acc.pair == PAIR_SEL_W'(p));

        dualbank_ram_bank u_even (
            .clk   (clk),
            .we    (ram_wr && pair_sel && acc.en_lo),
            .idx   (acc.idx),
            .wdata (wr_word.lo),
            .rdata (ram_rd_lo[p])
        );

        dualbank_ram_bank u_odd (
            .clk   (clk),
            .we    (ram_wr && pair_sel && acc.en_hi),
            .idx   (acc.idx),
            .wdata (wr_word.hi),
            .rdata (ram_rd_hi[p])
        );
    end

    dualbank_rom_bank #(.ODD(1'b0)) u_rom_even (
        .idx   (acc.idx),
        .rdata (rom_word.lo)
    );

    dualbank_rom_bank #(.ODD(1'b1)) u_rom_odd (
        .idx   (acc.idx),
        .rdata (rom_word.hi)
    );

    always_comb begin
        ram_word.lo = ram_rd_lo[acc.pair];
        ram_word.hi = ram_rd_hi[acc.pair];
    end

    always_comb begin
        next_word = '0;
        unique case (acc.region)
            RGN_ROM: begin
                if (acc.en_lo) next_word.lo = rom_word.lo;
                if (acc.en_hi) next_word.hi = rom_word.hi;
            end
            RGN_RAM: begin
                if (acc.en_lo) next_word.lo = ram_word.lo;
                if (acc.en_hi) next_word.hi = ram_word.hi;
            end
            default: next_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q    <= '0;
            unmapped_q <= 1'b0;
        end else begin
            unmapped_q <= bus_strobe && (acc.region == RGN_NONE);
            if (bus_strobe && !bus_we)
                rdata_q <= next_word;
        end
    end

    assign bus_rdata    = rdata_q;
    assign bus_unmapped = unmapped_q;
endmodule

// File: rtl/dualbank_mem_chk.sv
module dualbank_mem_chk
    import dualbank_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        bus_strobe,
    input logic        bus_we,
    input logic [19:0] bus_addr,
    input logic        bus_bhe_n,
    input logic [15:0] bus_rdata,
    input logic        bus_unmapped
);
    logic rd_go;
    assign rd_go = bus_strobe && !bus_we;

    assert_even_off_R4: assert property (@(posedge clk) disable iff (rst)
        rd_go && bus_addr[0] |=> bus_rdata[7:0] == 8'h00);

    assert_odd_off_R4: assert property (@(posedge clk) disable iff (rst)
        rd_go && bus_bhe_n |=> bus_rdata[15:8] == 8'h00);

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> $stable(bus_rdata));

    assert_unmapped_set_R10: assert property (@(posedge clk) disable iff (rst)
        bus_strobe && (bus_addr >= RAM_END) |=> bus_unmapped);

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        rd_go && (bus_addr >= RAM_END) |=> bus_rdata == 16'h0000);

    assert_unmapped_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !bus_strobe || (bus_addr < RAM_END) |=> !bus_unmapped);

    assert_rom_even_R8: assert property (@(posedge clk) disable iff (rst)
        rd_go && (bus_addr < ROM_END) && !bus_addr[0]
        |=> bus_rdata[7:0] == ($past(bus_addr[8:1]) ^ 8'h5A));
endmodule

bind dualbank_mem dualbank_mem_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_strobe   (bus_strobe),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_bhe_n    (bus_bhe_n),
    .bus_rdata    (bus_rdata),
    .bus_unmapped (bus_unmapped)
);

// File: tb/dualbank_mem_bench.sv
module dualbank_mem_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_strobe = 1'b0;
    logic        bus_we = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        bus_bhe_n = 1'b1;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_unmapped;

    always #4 clk = ~clk;

    dualbank_mem u_dualbank_mem (
        .clk          (clk),
        .rst          (rst),
        .bus_strobe   (bus_strobe),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_bhe_n    (bus_bhe_n),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_unmapped (bus_unmapped)
    );

    typedef struct {
        logic [15:0] data;
        logic [15:0] mask;
        logic        unm;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    logic [7:0]  model [int];
    int          n_checks = 0;
    int          n_fail = 0;
    logic        seen = 1'b0;
    logic [15:0] last_rd = '0;
    bit          done = 0;

    function automatic logic [7:0] rom_exp(input logic odd, input logic [10:0] i);
        return odd ? (i[10:3] ^ 8'hC3) : (i[7:0] ^ 8'h5A);
    endfunction

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp, input logic [15:0] mask);
        n_checks++;
        if ((act & mask) !== (exp & mask)) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (mask %h)", req, act, exp, mask);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Driver: one strobed access per call, expected item pushed to the scoreboard.
    task automatic access(input logic we, input logic [19:0] a, input logic bhe_n,
                          input logic [15:0] wd, input string req);
        exp_t e;
        int   ea;
        bit   is_rom, is_ram;
        ea     = int'({a[19:1], 1'b0});
        is_rom = a < 20'h01000;
        is_ram = (a >= 20'h01000) && (a < 20'h03000);
        e.req  = req;
        e.unm  = !(is_rom || is_ram);
        e.data = '0;
        e.mask = 16'hFFFF;
        if (we) begin
            e.mask = 16'h0000;
            if (is_ram) begin
                if (!a[0])  model[ea]     = wd[7:0];
                if (!bhe_n) model[ea + 1] = wd[15:8];
            end
        end else begin
            if (!a[0]) begin
                if (is_rom) e.data[7:0] = rom_exp(1'b0, a[11:1]);
                else if (is_ram) begin
                    if (model.exists(ea)) e.data[7:0] = model[ea];
                    else e.mask[7:0] = 8'h00;
                end
            end
            if (!bhe_n) begin
                if (is_rom) e.data[15:8] = rom_exp(1'b1, a[11:1]);
                else if (is_ram) begin
                    if (model.exists(ea + 1)) e.data[15:8] = model[ea + 1];
                    else e.mask[15:8] = 8'h00;
                end
            end
            last_rd = e.data;
        end
        sb_q.push_back(e);
        @(negedge clk);
        bus_strobe = 1'b1;
        bus_we     = we;
        bus_addr   = a;
        bus_bhe_n  = bhe_n;
        bus_wdata  = wd;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bus_strobe = 1'b0;
            bus_we     = 1'b0;
        end
    endtask

    always @(posedge clk) seen <= bus_strobe && !rst;

    // Monitor: pops one expected item per strobed cycle, one clock later.
    always @(negedge clk) begin
        if (seen) begin
            if (sb_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL scoreboard: result with no expected item");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.req, bus_rdata, e.data, e.mask);
                check({e.req, " flag"}, {15'd0, bus_unmapped}, {15'd0, e.unm}, 16'h0001);
            end
        end else if (!rst) begin
            check("R10 idle flag", {15'd0, bus_unmapped}, 16'h0000, 16'h0001);
        end
    end

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        check("R1 rdata", bus_rdata, 16'h0000, 16'hFFFF);
        check("R1 flag", {15'd0, bus_unmapped}, 16'h0000, 16'h0001);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", bus_rdata, 16'h0000, 16'hFFFF);

        // ROM words and bytes
        access(0, 20'h00000, 0, 0, "R8 rom word 0");
        access(0, 20'h0000A, 0, 0, "R8 rom word 5");
        access(0, 20'h00FFE, 0, 0, "R7 rom last word");
        access(0, 20'h00010, 1, 0, "R2 rom even byte");
        access(0, 20'h00021, 0, 0, "R3 rom odd byte");
        access(0, 20'h00031, 1, 0, "R4 rom no lane");
        // ROM write protection, back to back with reads
        access(1, 20'h00004, 0, 16'hFFFF, "R9 rom write");
        access(0, 20'h00004, 0, 0, "R9 rom after write");
        access(1, 20'h00FFF, 0, 16'h1111, "R9 rom odd write");
        access(0, 20'h00FFE, 0, 0, "R9 rom last after write");

        // RAM word then byte merges
        access(1, 20'h01000, 0, 16'h1234, "R6 ram word write");
        access(0, 20'h01000, 0, 0, "R6 ram word read");
        access(1, 20'h01000, 1, 16'h77AB, "R5 even byte write");
        access(0, 20'h01000, 0, 0, "R5 after even byte");
        access(1, 20'h01001, 0, 16'hCD88, "R5 odd byte write");
        access(0, 20'h01000, 0, 0, "R5 after odd byte");
        access(0, 20'h01001, 0, 0, "R3 ram odd byte read");
        access(0, 20'h01000, 1, 0, "R2 ram even byte read");

        // no-lane write leaves word intact
        access(1, 20'h01003, 1, 16'hFFFF, "R4 no-lane write");
        access(1, 20'h01002, 0, 16'h5566, "R6 ram word write 2");
        access(1, 20'h01003, 1, 16'hFFFF, "R4 no-lane write 2");
        access(0, 20'h01002, 0, 0, "R4 word unchanged");
        access(0, 20'h01003, 1, 0, "R4 no-lane read");

        // pair boundaries and aliasing
        access(1, 20'h01FFE, 0, 16'hA1A2, "R7 pair0 last");
        access(1, 20'h02000, 0, 16'hB1B2, "R7 pair1 first");
        access(1, 20'h02002, 0, 16'hC1C2, "R7 pair1 alias");
        access(1, 20'h02FFE, 0, 16'hD1D2, "R7 pair1 last");
        access(0, 20'h00FFE, 0, 0, "R7 rom edge");
        access(0, 20'h01FFE, 0, 0, "R7 pair0 last read");
        access(0, 20'h02000, 0, 0, "R7 pair1 first read");
        access(0, 20'h01002, 0, 0, "R7 pair0 not aliased");
        access(0, 20'h02002, 0, 0, "R7 pair1 alias read");
        access(0, 20'h02FFE, 0, 0, "R7 pair1 last read");

        // unmapped
        access(0, 20'h03000, 0, 0, "R10 first unmapped read");
        access(1, 20'h03000, 0, 16'h9999, "R10 unmapped write");
        access(1, 20'hFFFFE, 0, 16'h9999, "R10 top write");
        access(0, 20'h80000, 0, 0, "R10 high read");
        access(0, 20'h02FFE, 0, 0, "R10 ram untouched");

        // hold
        idle(1);
        idle(4);
        check("R11 hold", bus_rdata, last_rd, 16'hFFFF);
        access(1, 20'h01000, 0, 16'h0F0F, "R11 write keeps rdata");
        idle(2);
        check("R11 hold after write", bus_rdata, last_rd, 16'hFFFF);

        // mixed traffic through the RAM window
        lfsr = 16'hACE1;
        for (int it = 0; it < 400; it++) begin
            logic [19:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = 20'h01000 + {7'd0, lfsr[12:0]};
            access(lfsr[14], a, lfsr[15], {lfsr[7:0], lfsr[15:8]}, "R6 mixed");
        end
        idle(3);
        if (sb_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule